// File: doc/BRIEF.md
# Interrupt Priority Group Mask Unit

This block turns an 8-bit interrupt priority into its group priority for preemption decisions in an interrupt controller CPU interface. It holds binary point settings for group 0, secure group 1 and non-secure group 1. A separate virtual set holds a group 0 setting and a group 1 setting. A binary point value splits the priority into an upper group part and a lower subpriority part. The block returns a mask that clears the subpriority bits, together with the priority with that mask applied.

Non-secure group 1, and virtual group 1, interpret their binary point one position lower than group 0. Their minimum is therefore one above the group 0 minimum. A common binary point control exists for each security state, and one more exists for the virtual set. When a control is set, group 1 queries take the group 0 setting without any offset. Writes are clamped up to each register's floor. Queries are answered from registered outputs one cycle later.

Top module: `prio_group_mask`

## Requirements
- R1: After reset the physical group 0 and secure group 1 binary points equal MIN_BP, the physical non-secure group 1 binary point equals MIN_BP+1, the virtual group 0 binary point equals VMIN_BP, and the virtual group 1 binary point equals VMIN_BP+1. All common controls are clear, and o_valid, o_mask and o_gprio are 0.
- R2: A group 0 query (q_group=0) with binary point N gives o_mask = 8'hFF shifted left by N+1. N=7 gives a mask and group priority of 0.
- R3: A physical non-secure group 1 query (q_group=2) with the control clear uses binary point N minus one: o_mask = 8'hFF shifted left by N. N=1 keeps bits [7:1] and N=7 keeps bit 7 only.
- R4: A physical secure group 1 query (q_group=1) with the control clear uses the secure group 1 register with no offset.
- R5: When ctl_data bit 0 is set, secure group 1 queries use the group 0 register. When ctl_data bit 1 is set, non-secure group 1 queries use the group 0 register. In both cases no offset applies, and each control affects only its own security state.
- R6: Writes store wr_bp (3 bits), raised to the register's floor when below it. The floor is MIN_BP for group 0 and secure group 1, and MIN_BP+1 for non-secure group 1.
- R7: With q_virt set, the virtual set answers. Group codes 1 and 2 use virtual group 1 with the minus-one offset, unless ctl_data bit 2 (virtual control) is set, in which case they use virtual group 0 with no offset. Virtual writes to wr_sel 1 or 2 target virtual group 1, whose floor is VMIN_BP+1. The floor of virtual group 0 is VMIN_BP.
- R8: o_valid follows q_valid one cycle later. When valid, o_gprio = q_prio AND o_mask. o_mask and o_gprio hold their values while q_valid is low.
- R9: A query in the same cycle as a write or control update sees the values from before the update. wr_sel=3 writes nothing. q_group=3 behaves as group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Binary point write strobe |
| wr_virt | input | 1 | Write targets the virtual set |
| wr_sel | input | 2 | Register: 0 group 0, 1 secure group 1, 2 non-secure group 1, 3 none |
| wr_bp | input | BP_W | Binary point value to write |
| ctl_we | input | 1 | Common control write strobe |
| ctl_data | input | 3 | bit0 secure, bit1 non-secure, bit2 virtual common control |
| q_valid | input | 1 | Query strobe |
| q_virt | input | 1 | Query uses the virtual set |
| q_group | input | 2 | Interrupt group code (as wr_sel; 3 acts as group 0) |
| q_prio | input | PRIO_W | Priority value |
| o_valid | output | 1 | Registered query result valid |
| o_mask | output | PRIO_W | Group priority mask |
| o_gprio | output | PRIO_W | Masked group priority |

## Verification
A register write, or a common control update, can land in the same cycle as a query that reads the same register. In that case the answer must reflect the old setting. Directed steps provoke this by writing group 0 and toggling the non-secure control while querying the affected group in that same cycle. The random phase also produces many such collisions. The bench's model computes each expected value from the state before the update and then applies the update, so an answer that used the new value shows as a mismatch.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {
    GRP_0   = 2'd0,
    GRP_1S  = 2'd1,
    GRP_1NS = 2'd2,
    GRP_RSV = 2'd3
  } grp_e;

  localparam int CTL_S_BIT  = 0;
  localparam int CTL_NS_BIT = 1;
  localparam int CTL_V_BIT  = 2;
  localparam int CTL_W      = 3;
endpackage

// File: rtl/bp_bank.sv
module bp_bank #(
  parameter int BP_W   = 3,
  parameter int MIN_BP = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [BP_W-1:0] wr_bp,
  input  logic            ctl_we,
  input  logic            ctl_s,
  input  logic            ctl_ns,
  output logic [BP_W-1:0] g0,
  output logic [BP_W-1:0] g1s,
  output logic [BP_W-1:0] g1ns,
  output logic            cb_s,
  output logic            cb_ns
);
  import pgm_pkg::*;

  localparam logic [BP_W-1:0] FLOOR_LO = BP_W'(MIN_BP);
  localparam logic [BP_W-1:0] FLOOR_HI = BP_W'(MIN_BP + 1);

  logic [BP_W-1:0] lo_val, hi_val;

  always_comb begin
    lo_val = (wr_bp < FLOOR_LO) ? FLOOR_LO : wr_bp;
    hi_val = (wr_bp < FLOOR_HI) ? FLOOR_HI : wr_bp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g0    <= FLOOR_LO;
      g1s   <= FLOOR_LO;
      g1ns  <= FLOOR_HI;
      cb_s  <= 1'b0;
      cb_ns <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          GRP_0:   g0   <= lo_val;
          GRP_1S:  g1s  <= lo_val;
          GRP_1NS: g1ns <= hi_val;
          default: ;
        endcase
      end
      if (ctl_we) begin
        cb_s  <= ctl_s;
        cb_ns <= ctl_ns;
      end
    end
  end

  // R6: offset register never sits below its floor
  a_r6_ns_floor: assert property (@(posedge clk) disable iff (rst)
    g1ns >= FLOOR_HI);

  // R6: low write is raised to the floor
  a_r6_raise_low: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel == GRP_1NS && wr_bp < FLOOR_HI |=> g1ns == FLOOR_HI);

  // R6: in-range write is stored as given
  a_r6_keep_value: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel == GRP_0 && wr_bp >= FLOOR_LO |=> g0 == $past(wr_bp));

  // R9: reserved select leaves every register alone
  a_r9_rsv_ignored: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel == GRP_RSV |=> $stable(g0) && $stable(g1s) && $stable(g1ns));
endmodule

// File: rtl/bp_select.sv
module bp_select #(
  parameter int BP_W = 3
) (
  input  logic            virt,
  input  logic [1:0]      grp,
  input  logic [BP_W-1:0] p_g0,
  input  logic [BP_W-1:0] p_g1s,
  input  logic [BP_W-1:0] p_g1ns,
  input  logic            p_cb_s,
  input  logic            p_cb_ns,
  input  logic [BP_W-1:0] v_g0,
  input  logic [BP_W-1:0] v_g1,
  input  logic            v_cb,
  output logic [BP_W-1:0] eff_bp
);
  import pgm_pkg::*;

  localparam logic [BP_W-1:0] ONE = BP_W'(1);

  logic grp_is_1;
  assign grp_is_1 = (grp == GRP_1S) || (grp == GRP_1NS);

  always_comb begin
    if (virt) begin
      eff_bp = (grp_is_1 && !v_cb) ? (v_g1 - ONE) : v_g0;
    end else begin
      case (grp)
        GRP_1S:  eff_bp = p_cb_s  ? p_g0 : p_g1s;
        GRP_1NS: eff_bp = p_cb_ns ? p_g0 : (p_g1ns - ONE);
        default: eff_bp = p_g0;
      endcase
    end
  end
endmodule

// File: rtl/mask_gen.sv
module mask_gen #(
  parameter int PRIO_W = 8,
  parameter int BP_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_valid,
  input  logic [BP_W-1:0]   eff_bp,
  input  logic [PRIO_W-1:0] q_prio,
  output logic              o_valid,
  output logic [PRIO_W-1:0] o_mask,
  output logic [PRIO_W-1:0] o_gprio
);
  localparam logic [PRIO_W-1:0] ALL1 = {PRIO_W{1'b1}};

  logic [BP_W:0]     shamt;
  logic [PRIO_W-1:0] mask_c;

  always_comb begin
    shamt  = {1'b0, eff_bp} + (BP_W+1)'(1);
    mask_c = ALL1 << shamt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_mask  <= '0;
      o_gprio <= '0;
    end else begin
      o_valid <= q_valid;
      if (q_valid) begin
        o_mask  <= mask_c;
        o_gprio <= q_prio & mask_c;
      end
    end
  end

  // R8: group priority carries no subpriority bit
  a_r8_no_sub_bits: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_gprio & ~o_mask) == '0);

  // R2: mask is a run of ones from the top, bit 0 always clear
  a_r2_mask_shape: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> ((o_mask | (o_mask - 1'b1)) == ALL1) && !o_mask[0]);

  // R8: outputs hold while no query
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> $stable(o_mask) && $stable(o_gprio));

  // R8: valid follows query by one cycle
  a_r8_valid_lag: assert property (@(posedge clk) disable iff (rst)
    q_valid |=> o_valid);
endmodule

// File: rtl/prio_group_mask.sv
module prio_group_mask #(
  parameter int PRIO_W  = 8,
  parameter int MIN_BP  = 0,
  parameter int VMIN_BP = 0,
  localparam int BP_W   = $clog2(PRIO_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_virt,
  input  logic [1:0]        wr_sel,
  input  logic [BP_W-1:0]   wr_bp,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_data,
  input  logic              q_valid,
  input  logic              q_virt,
  input  logic [1:0]        q_group,
  input  logic [PRIO_W-1:0] q_prio,
  output logic              o_valid,
  output logic [PRIO_W-1:0] o_mask,
  output logic [PRIO_W-1:0] o_gprio
);
  import pgm_pkg::*;

  logic [BP_W-1:0] p_g0, p_g1s, p_g1ns, v_g0, v_g1s_unused, v_g1;
  logic            p_cb_s, p_cb_ns, v_cb, v_cb_dup;
  logic            p_wr, v_wr;
  logic [1:0]      v_sel;
  logic [BP_W-1:0] eff_bp;

  assign p_wr  = wr_en && !wr_virt;
  assign v_wr  = wr_en && wr_virt;
  // virtual set has one group 1 register: both group 1 codes land there
  assign v_sel = (wr_sel == GRP_1S) ? GRP_1NS : wr_sel;

  bp_bank #(.BP_W(BP_W), .MIN_BP(MIN_BP)) u_phys (
    .clk(clk), .rst(rst),
    .wr_en(p_wr), .wr_sel(wr_sel), .wr_bp(wr_bp),
    .ctl_we(ctl_we), .ctl_s(ctl_data[CTL_S_BIT]), .ctl_ns(ctl_data[CTL_NS_BIT]),
    .g0(p_g0), .g1s(p_g1s), .g1ns(p_g1ns), .cb_s(p_cb_s), .cb_ns(p_cb_ns)
  );

  bp_bank #(.BP_W(BP_W), .MIN_BP(VMIN_BP)) u_virt (
    .clk(clk), .rst(rst),
    .wr_en(v_wr), .wr_sel(v_sel), .wr_bp(wr_bp),
    .ctl_we(ctl_we), .ctl_s(ctl_data[CTL_V_BIT]), .ctl_ns(ctl_data[CTL_V_BIT]),
    .g0(v_g0), .g1s(v_g1s_unused), .g1ns(v_g1), .cb_s(v_cb), .cb_ns(v_cb_dup)
  );

  bp_select #(.BP_W(BP_W)) u_sel (
    .virt(q_virt), .grp(q_group),
    .p_g0(p_g0), .p_g1s(p_g1s), .p_g1ns(p_g1ns),
    .p_cb_s(p_cb_s), .p_cb_ns(p_cb_ns),
    .v_g0(v_g0), .v_g1(v_g1), .v_cb(v_cb),
    .eff_bp(eff_bp)
  );

  mask_gen #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_mask (
    .clk(clk), .rst(rst), .q_valid(q_valid), .eff_bp(eff_bp), .q_prio(q_prio),
    .o_valid(o_valid), .o_mask(o_mask), .o_gprio(o_gprio)
  );

  // R3: offset group without redirect always keeps the top priority bit
  a_r3_ns_keeps_msb: assert property (@(posedge clk) disable iff (rst)
    q_valid && !q_virt && q_group == GRP_1NS && !p_cb_ns |=> o_mask[PRIO_W-1]);

  // R7: virtual group 1 without redirect always keeps the top bit
  a_r7_virt_msb: assert property (@(posedge clk) disable iff (rst)
    q_valid && q_virt && q_group == GRP_1S && !v_cb |=> o_mask[PRIO_W-1]);

  // R5: both redirect copies of the virtual control agree
  a_r5_virt_ctl_pair: assert property (@(posedge clk) disable iff (rst)
    v_cb == v_cb_dup);
endmodule

// File: tb/sim_prio_group_mask.sv
module sim_prio_group_mask;
  localparam int MIN_BP  = 1;
  localparam int VMIN_BP = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, wr_virt = 0, ctl_we = 0, q_valid = 0, q_virt = 0;
  logic [1:0] wr_sel = 0, q_group = 0;
  logic [2:0] wr_bp = 0, ctl_data = 0;
  logic [7:0] q_prio = 0;
  logic       o_valid;
  logic [7:0] o_mask, o_gprio;

  int tests = 0, fails = 0;
  int m_pg0, m_pg1s, m_pg1ns, m_vg0, m_vg1;
  bit m_cs, m_cns, m_vc;
  logic [7:0] last_mask, last_gprio;

  always #5 clk = ~clk;

  prio_group_mask #(.PRIO_W(8), .MIN_BP(MIN_BP), .VMIN_BP(VMIN_BP)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_virt(wr_virt), .wr_sel(wr_sel),
    .wr_bp(wr_bp), .ctl_we(ctl_we), .ctl_data(ctl_data), .q_valid(q_valid),
    .q_virt(q_virt), .q_group(q_group), .q_prio(q_prio), .o_valid(o_valid),
    .o_mask(o_mask), .o_gprio(o_gprio));

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int eff_of(int g, bit v);
    if (v) begin
      if ((g == 1 || g == 2) && !m_vc) return m_vg1 - 1;
      return m_vg0;
    end
    if (g == 1) return m_cs ? m_pg0 : m_pg1s;
    if (g == 2) return m_cns ? m_pg0 : m_pg1ns - 1;
    return m_pg0;
  endfunction

  function automatic logic [7:0] mask_of(int e);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i >= e + 1);
    return m;
  endfunction

  task automatic step(string tag, bit qv, int g, bit qvirt, logic [7:0] pr,
                      bit we, bit wv, int sel, int bp, bit cwe, logic [2:0] cd);
    logic [7:0] em;
    q_valid = qv; q_group = 2'(g); q_virt = qvirt; q_prio = pr;
    wr_en = we; wr_virt = wv; wr_sel = 2'(sel); wr_bp = 3'(bp);
    ctl_we = cwe; ctl_data = cd;
    em = mask_of(eff_of(g, qvirt));
    if (cwe) begin m_cs = cd[0]; m_cns = cd[1]; m_vc = cd[2]; end
    if (we) begin
      if (wv) begin
        if (sel == 0) m_vg0 = maxi(bp & 7, VMIN_BP);
        else if (sel != 3) m_vg1 = maxi(bp & 7, VMIN_BP + 1);
      end else begin
        if (sel == 0) m_pg0 = maxi(bp & 7, MIN_BP);
        else if (sel == 1) m_pg1s = maxi(bp & 7, MIN_BP);
        else if (sel == 2) m_pg1ns = maxi(bp & 7, MIN_BP + 1);
      end
    end
    @(negedge clk);
    if (qv) begin
      last_mask = em; last_gprio = pr & em;
      chk(tag, "valid", {7'd0, o_valid}, 8'd1);
    end else begin
      chk("R8", "valid", {7'd0, o_valid}, 8'd0);
    end
    chk(tag, "mask", o_mask, last_mask);
    chk(tag, "gprio", o_gprio, last_gprio);
    q_valid = 0; wr_en = 0; ctl_we = 0;
  endtask

  task automatic query(string tag, int g, bit v, logic [7:0] pr);
    step(tag, 1, g, v, pr, 0, 0, 0, 0, 0, 3'd0);
  endtask

  task automatic wr(bit v, int sel, int bp);
    step("R6", 0, 0, 0, 8'h00, 1, v, sel, bp, 0, 3'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_pg0 = MIN_BP; m_pg1s = MIN_BP; m_pg1ns = MIN_BP + 1;
    m_vg0 = VMIN_BP; m_vg1 = VMIN_BP + 1;
    m_cs = 0; m_cns = 0; m_vc = 0;
    last_mask = 0; last_gprio = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", "reset valid", {7'd0, o_valid}, 8'd0);
    chk("R1", "reset mask", o_mask, 8'h00);
    chk("R1", "reset gprio", o_gprio, 8'h00);
    // R1 reset register values seen through queries
    query("R1", 0, 0, 8'hFF);
    query("R1", 1, 0, 8'hFF);
    query("R1", 2, 0, 8'hFF);
    query("R1", 0, 1, 8'hFF);
    query("R1", 2, 1, 8'hFF);
    // R2 binary point 7 leaves no group bits
    wr(0, 0, 7);
    query("R2", 0, 0, 8'hFF);
    chk("R2", "bp7 mask", o_mask, 8'h00);
    query("R2", 3, 0, 8'hA5);
    // R6 clamp on the offset register, then R3 extremes
    wr(0, 2, 0);
    query("R6", 2, 0, 8'hFF);
    wr(0, 2, 7);
    query("R3", 2, 0, 8'hF0);
    chk("R3", "bp7 keeps msb", o_mask, 8'h80);
    // R4 secure group 1 without offset
    wr(0, 1, 3);
    query("R4", 1, 0, 8'h5B);
    chk("R4", "bp3 mask", o_mask, 8'hF0);
    // R9 same-cycle write: old group 0 value (7) still answers
    step("R9", 1, 0, 0, 8'hFF, 1, 0, 0, 2, 0, 3'd0);
    chk("R9", "old bp", o_mask, 8'h00);
    query("R9", 0, 0, 8'hFF);
    // R9 same-cycle control update, then R5 redirect
    step("R9", 1, 2, 0, 8'hFF, 0, 0, 0, 0, 1, 3'b010);
    query("R5", 2, 0, 8'hFF);
    query("R5", 1, 0, 8'hFF);
    step("R5", 0, 0, 0, 8'h00, 0, 0, 0, 0, 1, 3'b001);
    query("R5", 1, 0, 8'hFF);
    query("R5", 2, 0, 8'hFF);
    // R9 reserved select writes nothing
    step("R9", 0, 0, 0, 8'h00, 1, 0, 3, 6, 0, 3'd0);
    query("R9", 0, 0, 8'hFF);
    query("R9", 1, 0, 8'hFF);
    query("R9", 2, 0, 8'hFF);
    // R7 virtual set
    wr(1, 1, 0);
    query("R7", 1, 1, 8'hFF);
    wr(1, 0, 0);
    query("R7", 0, 1, 8'hFF);
    step("R7", 0, 0, 0, 8'h00, 0, 0, 0, 0, 1, 3'b100);
    query("R7", 2, 1, 8'hFF);
    // R8 hold while idle
    step("R8", 0, 1, 0, 8'h3C, 0, 0, 0, 0, 0, 3'd0);
    // random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      bit qv, qvi, we, wv, cwe;
      int g, sel, bp;
      logic [7:0] pr;
      string tag;
      qv  = ($urandom % 4) != 0;
      g   = $urandom % 4;
      qvi = $urandom % 2;
      pr  = 8'($urandom);
      we  = ($urandom % 3) == 0;
      wv  = $urandom % 2;
      sel = $urandom % 4;
      bp  = $urandom % 8;
      cwe = ($urandom % 8) == 0;
      if (!qv) tag = "R8";
      else if (we && wv == qvi) tag = "R9";
      else if (qvi) tag = "R7";
      else if (g == 1) tag = m_cs ? "R5" : "R4";
      else if (g == 2) tag = m_cns ? "R5" : "R3";
      else tag = "R2";
      step(tag, qv, g, qvi, pr, we, wv, sel, bp, cwe, 3'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule